// File: doc/BRIEF.md
# Standby Refresh Command Decoder

This block sits on the device side of a pseudo-static memory. While the chip is deselected (chip enable high, active-low `ce_n`), the shared output-enable pin `oe_refresh_n` acts as a refresh command. The decoder measures how long each low level of that pin lasts. A short pulse is ignored. A pulse of medium width asks for one automatic refresh. A long hold puts the device into self refresh. In self refresh an internal timer keeps refreshing rows without any further command.

Each row refresh appears as a one-cycle `refresh_strobe`. `refresh_row` gives the row to refresh, taken from an internal wrapping counter. Arming guards against false commands: the pin must be seen high in standby before a falling edge counts. The same applies when chip enable rises while the pin is still low after an access. Leaving self refresh always passes through a fixed reset interval, and pin activity during that interval is not taken as a command. Pulse widths and intervals are given in clock cycles. With a 5 ns clock, the defaults are 80 ns, 8 µs, 15.6 µs and 600 ns.

Top module: `rfsh_pulse_decoder`

## Requirements
- R1: During and right after reset, `refresh_mode` is 0 (disarmed), `refresh_strobe` is 0, `refresh_row` is 0 and `self_refresh_active` is 0.
- R2: A falling edge of `oe_refresh_n` is measured only after the pin has been sampled high with `ce_n` high. This must happen after reset, after an access and after a self-refresh exit. `refresh_mode` is 1 once armed. A pin held low through a rising `ce_n` starts nothing.
- R3: A standby low pulse shorter than MIN_PULSE sampled cycles produces no strobe, and the decoder returns to armed.
- R4: A standby low pulse of at least MIN_PULSE and fewer than SELF_THRESH cycles produces exactly one strobe, issued after the pin returns high.
- R5: When the low level reaches SELF_THRESH cycles, `refresh_mode` becomes 3 and `self_refresh_active` becomes 1. One strobe is issued on entry.
- R6: While self refresh holds, one further strobe follows every SELF_INTERVAL cycles. A hold of W cycles (W ≥ SELF_THRESH) gives 1 + floor((W − SELF_THRESH) / SELF_INTERVAL) strobes in total.
- R7: The pin going high or `ce_n` going low in self refresh leads to `refresh_mode` 4 for exactly EXIT_CYCLES cycles. No strobe is issued in that state, and falling edges during it are ignored. Afterwards the decoder is disarmed.
- R8: `refresh_row` is the row of the current strobe. It advances by one in the cycle after each strobe, wraps from 2^ROW_W − 1 to 0, and is otherwise unchanged.
- R9: `ce_n` going low while a pulse is being measured (`refresh_mode` 2) discards the request, so no strobe is issued.
- R10: `refresh_strobe` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low; high means standby |
| oe_refresh_n | input | 1 | Shared output-enable / refresh command pin, active low |
| refresh_strobe | output | 1 | One-cycle row refresh request |
| refresh_row | output | ROW_W | Row address for the current strobe |
| refresh_mode | output | 3 | 0 disarmed, 1 armed, 2 measuring, 3 self refresh, 4 exit interval |
| self_refresh_active | output | 1 | High while in self refresh |

## Verification
The assertions take for granted that both pins are level signals. They may be asynchronous to `clk`, but each level must last longer than the synchronizer depth, so the sampled widths equal the driven widths. The stimulus changes pins only at falling clock edges and holds each level for whole cycles. After every command it waits long enough in standby with the pin high for any exit interval and re-arming to finish, so each sweep step starts from the armed state. The sweep covers every pulse width from one cycle to beyond three self-refresh intervals.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    typedef enum logic [2:0] {
        RF_DISARMED = 3'd0,
        RF_ARMED    = 3'd1,
        RF_MEASURE  = 3'd2,
        RF_SELF     = 3'd3,
        RF_EXIT     = 3'd4
    } rf_mode_e;

endpackage

// File: rtl/rfsh_sync.sv
module rfsh_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_raw,
    input  logic pin_raw,
    output logic ce_n_s,
    output logic pin_s
);
    // bit 0: chip enable (resets to standby), bit 1: refresh pin (resets low = not armed)
    localparam logic [1:0] RST_VAL = 2'b01;

    logic [1:0] raw;
    logic [1:0] synced;

    assign raw = {pin_raw, ce_n_raw};

    for (genvar b = 0; b < 2; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            if (STAGES > 1) begin
                chain_d = {chain_q[STAGES-2:0], raw[b]};
            end else begin
                chain_d = raw[b];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
            else        chain_q <= chain_d;
        end

        assign synced[b] = chain_q[STAGES-1];
    end

    assign ce_n_s = synced[0];
    assign pin_s  = synced[1];

endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int INTERVAL = 3120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [ROW_W-1:0] row
);
    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (step) row_d = row_q + ROW_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else        row_q <= row_d;
    end

    assign row = row_q;

endmodule

// File: rtl/rfsh_classifier.sv
module rfsh_classifier
    import rfsh_pkg::*;
#(
    parameter int MIN_PULSE   = 16,
    parameter int SELF_THRESH = 1600,
    parameter int EXIT_CYCLES = 120
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ce_n_s,
    input  logic     pin_s,
    input  logic     tick,
    output logic     timer_run,
    output logic     strobe,
    output rf_mode_e mode
);
    localparam int MW = $clog2(SELF_THRESH + 1);
    localparam int EW = (EXIT_CYCLES > 1) ? $clog2(EXIT_CYCLES) : 1;
    localparam logic [MW-1:0] MIN_LIM   = MW'(MIN_PULSE);
    localparam logic [MW-1:0] SELF_LAST = MW'(SELF_THRESH - 1);
    localparam logic [EW-1:0] EXIT_LAST = EW'(EXIT_CYCLES - 1);

    typedef struct packed {
        rf_mode_e      mode;
        logic [MW-1:0] meas;
        logic [EW-1:0] exitc;
        logic          strobe;
    } cls_state_t;

    cls_state_t st_d, st_q;
    logic standby;

    assign standby   = ce_n_s;
    assign timer_run = (st_q.mode == RF_SELF) && standby && !pin_s;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        unique case (st_q.mode)
            RF_DISARMED: begin
                if (standby && pin_s) st_d.mode = RF_ARMED;
            end
            RF_ARMED: begin
                if (!standby) begin
                    st_d.mode = RF_DISARMED;
                end else if (!pin_s) begin
                    st_d.mode = RF_MEASURE;
                    st_d.meas = MW'(1);
                end
            end
            RF_MEASURE: begin
                if (!standby) begin
                    st_d.mode = RF_DISARMED;
                    st_d.meas = '0;
                end else if (!pin_s) begin
                    if (st_q.meas >= SELF_LAST) begin
                        st_d.mode   = RF_SELF;
                        st_d.strobe = 1'b1;
                        st_d.meas   = '0;
                    end else begin
                        st_d.meas = st_q.meas + MW'(1);
                    end
                end else begin
                    st_d.strobe = (st_q.meas >= MIN_LIM);
                    st_d.mode   = RF_ARMED;
                    st_d.meas   = '0;
                end
            end
            RF_SELF: begin
                if (!standby || pin_s) begin
                    st_d.mode  = RF_EXIT;
                    st_d.exitc = '0;
                end else if (tick) begin
                    st_d.strobe = 1'b1;
                end
            end
            RF_EXIT: begin
                if (st_q.exitc == EXIT_LAST) begin
                    st_d.mode  = RF_DISARMED;
                    st_d.exitc = '0;
                end else begin
                    st_d.exitc = st_q.exitc + EW'(1);
                end
            end
            default: begin
                st_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= RF_DISARMED;
            st_q.meas   <= '0;
            st_q.exitc  <= '0;
            st_q.strobe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe = st_q.strobe;
    assign mode   = st_q.mode;

    // R2
    arm_before_measure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == RF_DISARMED) |=> (st_q.mode != RF_MEASURE));

    // R5
    self_from_measure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mode == RF_SELF) |-> ($past(st_q.mode) == RF_MEASURE));

    // R7
    exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == RF_EXIT) |-> !st_q.strobe);

    // R9
    access_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == RF_MEASURE && !ce_n_s) |=> (!st_q.strobe && st_q.mode == RF_DISARMED));

    // R10
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.strobe |=> !st_q.strobe);

endmodule

// File: rtl/rfsh_pulse_decoder.sv
module rfsh_pulse_decoder
    import rfsh_pkg::*;
#(
    parameter int ROW_W         = 11,
    parameter int MIN_PULSE     = 16,
    parameter int SELF_THRESH   = 1600,
    parameter int SELF_INTERVAL = 3120,
    parameter int EXIT_CYCLES   = 120,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             oe_refresh_n,
    output logic             refresh_strobe,
    output logic [ROW_W-1:0] refresh_row,
    output logic [2:0]       refresh_mode,
    output logic             self_refresh_active
);
    logic     ce_n_s, pin_s;
    logic     tick, timer_run, strobe;
    rf_mode_e mode;

    rfsh_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n_raw (ce_n),
        .pin_raw  (oe_refresh_n),
        .ce_n_s   (ce_n_s),
        .pin_s    (pin_s)
    );

    rfsh_classifier #(
        .MIN_PULSE   (MIN_PULSE),
        .SELF_THRESH (SELF_THRESH),
        .EXIT_CYCLES (EXIT_CYCLES)
    ) u_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n_s    (ce_n_s),
        .pin_s     (pin_s),
        .tick      (tick),
        .timer_run (timer_run),
        .strobe    (strobe),
        .mode      (mode)
    );

    rfsh_interval_timer #(.INTERVAL(SELF_INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick)
    );

    rfsh_row_counter #(.ROW_W(ROW_W)) u_rows (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (strobe),
        .row   (refresh_row)
    );

    assign refresh_strobe      = strobe;
    assign refresh_mode        = mode;
    assign self_refresh_active = (mode == RF_SELF);

    // R8
    row_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_strobe |=> (refresh_row == $past(refresh_row) + ROW_W'(1)));

    // R8
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_strobe |=> $stable(refresh_row));

endmodule

// File: tb/rfsh_pulse_decoder_test.sv
module rfsh_pulse_decoder_test;
    localparam int ROW_W  = 4;
    localparam int MINP   = 4;
    localparam int THR    = 20;
    localparam int IVL    = 7;
    localparam int EXITC  = 6;
    localparam int SETTLE = EXITC + 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1;
    logic pin = 1'b0;
    logic             refresh_strobe;
    logic [ROW_W-1:0] refresh_row;
    logic [2:0]       refresh_mode;
    logic             self_refresh_active;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int exit_cyc = 0;
    int back_to_back = 0;
    int exp_total = 0;
    bit prev_strobe = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rfsh_pulse_decoder #(
        .ROW_W(ROW_W), .MIN_PULSE(MINP), .SELF_THRESH(THR),
        .SELF_INTERVAL(IVL), .EXIT_CYCLES(EXITC), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_refresh_n(pin),
        .refresh_strobe(refresh_strobe), .refresh_row(refresh_row),
        .refresh_mode(refresh_mode), .self_refresh_active(self_refresh_active)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (refresh_strobe) strobes++;
            if (refresh_strobe && prev_strobe) back_to_back++;
            if (refresh_mode == 3'd4) exit_cyc++;
            prev_strobe = refresh_strobe;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_strobes(input int w);
        if (w < MINP) return 0;
        if (w < THR) return 1;
        return 1 + (w - THR) / IVL;
    endfunction

    task automatic check_row(input string req);
        chk(req, int'(refresh_row), exp_total % (1 << ROW_W));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int s0;
        int e0;
        cyc(4);
        // R1 reset values
        chk("R1 mode", int'(refresh_mode), 0);
        chk("R1 strobe", int'(refresh_strobe), 0);
        chk("R1 row", int'(refresh_row), 0);
        chk("R1 self", int'(self_refresh_active), 0);
        rst_n = 1'b1;
        cyc(6);
        // R2 a pin held low from reset does not arm
        chk("R2 low from reset stays disarmed", int'(refresh_mode), 0);
        chk("R1 no strobe after reset", strobes, 0);
        pin = 1'b1;
        cyc(6);
        chk("R2 armed", int'(refresh_mode), 1);

        // sweep every width: R3 short, R4 auto, R5/R6 self, R7 exit length
        for (int w = 1; w <= THR + 3 * IVL + 4; w++) begin
            s0 = strobes;
            e0 = exit_cyc;
            pin = 1'b0;
            cyc(w);
            pin = 1'b1;
            cyc(SETTLE);
            exp_total += exp_strobes(w);
            if (w < MINP)      chk($sformatf("R3 width %0d", w), strobes - s0, 0);
            else if (w < THR)  chk($sformatf("R4 width %0d", w), strobes - s0, 1);
            else               chk($sformatf("R6 width %0d", w), strobes - s0, exp_strobes(w));
            chk($sformatf("R7 exit cycles width %0d", w), exit_cyc - e0, (w >= THR) ? EXITC : 0);
            chk($sformatf("R2 rearmed width %0d", w), int'(refresh_mode), 1);
            check_row($sformatf("R8 row after width %0d", w));
        end

        // R5 mode while self refresh holds
        s0 = strobes;
        pin = 1'b0;
        cyc(THR + 10);
        chk("R5 mode self", int'(refresh_mode), 3);
        chk("R5 self active", int'(self_refresh_active), 1);
        pin = 1'b1;
        cyc(4);
        chk("R7 mode exit", int'(refresh_mode), 4);
        chk("R5 self inactive in exit", int'(self_refresh_active), 0);
        cyc(SETTLE);
        exp_total += exp_strobes(THR + 10);
        chk("R6 strobes long hold", strobes - s0, exp_strobes(THR + 10));
        check_row("R8 row after long hold");

        // R7 falling edge inside the exit interval is ignored
        s0 = strobes;
        e0 = exit_cyc;
        pin = 1'b0;
        cyc(THR);
        pin = 1'b1;
        cyc(4);
        pin = 1'b0;
        cyc(MINP + 2);
        pin = 1'b1;
        cyc(SETTLE);
        exp_total += 1;
        chk("R7 no strobe from exit pulse", strobes - s0, 1);
        chk("R7 exit length", exit_cyc - e0, EXITC);
        chk("R7 rearmed after exit", int'(refresh_mode), 1);

        // R7 chip enable low ends self refresh
        s0 = strobes;
        e0 = exit_cyc;
        pin = 1'b0;
        cyc(THR + 5);
        ce_n = 1'b0;
        cyc(5);
        chk("R7 exit on access", int'(refresh_mode), 4);
        cyc(SETTLE);
        chk("R2 disarmed during access", int'(refresh_mode), 0);
        pin = 1'b1;
        ce_n = 1'b1;
        cyc(8);
        exp_total += 1;
        chk("R7 strobes before access", strobes - s0, 1);
        chk("R7 exit length on access", exit_cyc - e0, EXITC);
        chk("R2 armed after access", int'(refresh_mode), 1);

        // R9 access during measurement discards the request
        s0 = strobes;
        pin = 1'b0;
        cyc(3);
        ce_n = 1'b0;
        cyc(4);
        pin = 1'b1;
        cyc(2);
        ce_n = 1'b1;
        cyc(SETTLE);
        chk("R9 discarded", strobes - s0, 0);
        chk("R9 armed again", int'(refresh_mode), 1);

        // R2 pin low through chip enable rising starts nothing
        s0 = strobes;
        ce_n = 1'b0;
        pin = 1'b0;
        cyc(5);
        ce_n = 1'b1;
        cyc(MINP + 6);
        chk("R2 unarmed low hold mode", int'(refresh_mode), 0);
        pin = 1'b1;
        cyc(SETTLE);
        chk("R2 no refresh without arming", strobes - s0, 0);
        pin = 1'b0;
        cyc(MINP + 2);
        pin = 1'b1;
        cyc(SETTLE);
        exp_total += 1;
        chk("R2 refresh after arming", strobes - s0, 1);
        check_row("R8 row final");
        chk("R8 wrap exercised", int'(exp_total >= (1 << ROW_W)), 1);
        chk("R10 no back-to-back strobes", back_to_back, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule